// File: doc/BRIEF.md
# ADC Out-of-Range Alert Monitor

This block sits beside a multi-channel ADC core and checks every raw conversion result against one window that all channels share. The window is set by two 12-bit threshold fields. Each field is widened to a 16-bit limit by appending a fixed low nibble: all ones for the upper limit and all zeros for the lower limit. A result above the upper limit or below the lower limit is out of range. The comparison uses the raw sample as soon as the conversion finishes, before any averaging further down the chain. Cores with less than 16 bits of resolution have their results left-aligned into 16 bits, so the same limits apply to them.

An out-of-range result drives the active-low alert pin low after the conversion-done strobe. The pin stays low until the next falling edge of chip select, which is also the edge that starts the next conversion. A sticky status word keeps one bit per channel for each direction. Reading the status word clears it, and so does the chip-select falling edge. A configuration enable bit gates the whole function.

Top module: `adc_range_alert`

## Requirements
- R1: After reset the enable bit is 0, the upper field reads 0x7FF, the lower field reads 0x800, the status word reads 0 and `alert_n` is 1.
- R2: On a `conv_done` cycle with the block enabled, channel i sets status bit i when its 16-bit result is strictly greater than {upper field, 4'hF}. A result equal to that limit sets nothing.
- R3: On a `conv_done` cycle with the block enabled, channel i sets status bit NUM_CH+i when its result is strictly less than {lower field, 4'h0}. A result equal to that limit sets nothing.
- R4: `alert_n` is low in the cycle after an enabled `conv_done` in which any channel is out of range.
- R5: Once set, `alert_n` low and the status bits stay as they are across later conversions that are in range.
- R6: A falling edge of `cs_n` clears the status word and returns `alert_n` to 1 in the next cycle. A rising edge changes neither.
- R7: When the enable bit is 0, `alert_n` is 1 from the next cycle on, and conversions set no status bits.
- R8: A read (`reg_rd`) of address 3 clears the status word but leaves `alert_n` unchanged. Hits from the same cycle are kept.
- R9: If an out-of-range conversion and a `cs_n` falling edge fall in the same cycle, the new hit is kept: the old status is cleared, the new bits are set and `alert_n` is 0.
- R10: Register map on `reg_rdata`, which follows `reg_addr` combinationally. Address 0 bit 0 is the enable bit. Address 1 holds the upper field. Address 2 holds the lower field. Address 3 holds the status word. Writes take effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: results are valid |
| samples | input | NUM_CH*RES_BITS | Raw results, channel i at [i*RES_BITS +: RES_BITS] |
| cs_n | input | 1 | Chip select; a falling edge clears the alert |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the status word at address 3) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 12 | Write data |
| reg_rdata | output | 12 | Read data for `reg_addr` |
| alert_n | output | 1 | Active-low out-of-range alert |

## Verification
Every result of the block is due exactly one clock edge after the input that causes it. This covers status bits, `alert_n`, register writes and the clears from chip select or a read. `reg_rdata` is the exception: it changes in the same cycle as `reg_addr`. The bench applies each stimulus just after a falling clock edge, so it is stable across one rising edge. It then compares `alert_n` and `reg_rdata` against a behavioural model at the next falling edge. The directed checks sample at that same falling edge, which is the first point after the edge that registers the result.

// File: rtl/adc_alert_pkg.sv
`timescale 1ns/1ps
package adc_alert_pkg;
  localparam int CMP_W  = 16;
  localparam int TH_W   = 12;
  localparam int FILL_W = CMP_W - TH_W;

  typedef enum logic [1:0] {
    ADDR_CFG  = 2'd0,
    ADDR_HI   = 2'd1,
    ADDR_LO   = 2'd2,
    ADDR_STAT = 2'd3
  } alert_addr_e;

  // upper limit: field followed by an all-ones nibble
  function automatic logic [CMP_W-1:0] upper_limit(input logic [TH_W-1:0] f);
    return {f, {FILL_W{1'b1}}};
  endfunction

  // lower limit: field followed by an all-zeros nibble
  function automatic logic [CMP_W-1:0] lower_limit(input logic [TH_W-1:0] f);
    return {f, {FILL_W{1'b0}}};
  endfunction
endpackage

// File: rtl/alert_regs.sv
`timescale 1ns/1ps
module alert_regs
  import adc_alert_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [1:0]      addr,
  input  logic [TH_W-1:0] wdata,
  output logic            en,
  output logic [TH_W-1:0] hi_field,
  output logic [TH_W-1:0] lo_field
);
  localparam logic [TH_W-1:0] HI_RST = {1'b0, {(TH_W-1){1'b1}}};
  localparam logic [TH_W-1:0] LO_RST = {1'b1, {(TH_W-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      hi_field <= HI_RST;
      lo_field <= LO_RST;
    end else if (wr) begin
      case (alert_addr_e'(addr))
        ADDR_CFG: en       <= wdata[0];
        ADDR_HI:  hi_field <= wdata;
        ADDR_LO:  lo_field <= wdata;
        default:  ;
      endcase
    end
  end

  // R1: reset values of the threshold fields
  a_r1_reset_fields: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (hi_field == HI_RST && lo_field == LO_RST));
endmodule

// File: rtl/alert_compare.sv
`timescale 1ns/1ps
module alert_compare
  import adc_alert_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int RES_BITS = 16
) (
  input  logic [NUM_CH*RES_BITS-1:0] samples,
  input  logic [TH_W-1:0]            hi_field,
  input  logic [TH_W-1:0]            lo_field,
  output logic [NUM_CH-1:0]          over_hi,
  output logic [NUM_CH-1:0]          under_lo
);
  localparam int PAD_W = CMP_W - RES_BITS;

  logic [CMP_W-1:0] hi_lim, lo_lim;
  assign hi_lim = upper_limit(hi_field);
  assign lo_lim = lower_limit(lo_field);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CMP_W-1:0] val;
    if (PAD_W > 0) begin : g_pad
      assign val = {samples[ch*RES_BITS +: RES_BITS], {PAD_W{1'b0}}};
    end else begin : g_full
      assign val = samples[ch*RES_BITS +: RES_BITS];
    end
    assign over_hi[ch]  = val > hi_lim;
    assign under_lo[ch] = val < lo_lim;
  end
endmodule

// File: rtl/alert_status.sv
`timescale 1ns/1ps
module alert_status #(
  parameter int NUM_CH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conv_done,
  input  logic                en,
  input  logic [NUM_CH-1:0]   over_hi,
  input  logic [NUM_CH-1:0]   under_lo,
  input  logic                cs_n,
  input  logic                stat_rd,
  output logic [2*NUM_CH-1:0] status,
  output logic                alert_n
);
  logic              cs_q, cs_fall, latch_q, any_hit, stat_clr;
  logic [NUM_CH-1:0] hit_hi, hit_lo;

  assign hit_hi   = (conv_done && en) ? over_hi  : '0;
  assign hit_lo   = (conv_done && en) ? under_lo : '0;
  assign any_hit  = |{hit_hi, hit_lo};
  assign cs_fall  = cs_q && !cs_n;
  assign stat_clr = cs_fall || stat_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      latch_q <= 1'b0;
      status  <= '0;
    end else begin
      cs_q    <= cs_n;
      status  <= (stat_clr ? '0 : status) | {hit_lo, hit_hi};
      if (!en)          latch_q <= 1'b0;
      else if (any_hit) latch_q <= 1'b1;
      else if (cs_fall) latch_q <= 1'b0;
    end
  end

  assign alert_n = !latch_q;

  a_r4_alert_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && en && |{over_hi, under_lo}) |=> !alert_n);
  a_r5_alert_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_n && en && !cs_fall) |=> !alert_n);
  a_r6_cs_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && !(conv_done && en && |{over_hi, under_lo})) |=> (alert_n && status == '0));
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> alert_n);
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(conv_done && en)) |=> status == '0);
endmodule

// File: rtl/adc_range_alert.sv
`timescale 1ns/1ps
module adc_range_alert
  import adc_alert_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int RES_BITS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       conv_done,
  input  logic [NUM_CH*RES_BITS-1:0] samples,
  input  logic                       cs_n,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [1:0]                 reg_addr,
  input  logic [TH_W-1:0]            reg_wdata,
  output logic [TH_W-1:0]            reg_rdata,
  output logic                       alert_n
);
  localparam int STAT_W = 2 * NUM_CH;

  logic              en;
  logic [TH_W-1:0]   hi_field, lo_field;
  logic [NUM_CH-1:0] over_hi, under_lo;
  logic [STAT_W-1:0] status;
  logic              stat_rd;

  assign stat_rd = reg_rd && (alert_addr_e'(reg_addr) == ADDR_STAT);

  alert_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .en(en), .hi_field(hi_field), .lo_field(lo_field)
  );

  alert_compare #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) u_cmp (
    .samples(samples), .hi_field(hi_field), .lo_field(lo_field),
    .over_hi(over_hi), .under_lo(under_lo)
  );

  alert_status #(.NUM_CH(NUM_CH)) u_stat (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .en(en),
    .over_hi(over_hi), .under_lo(under_lo), .cs_n(cs_n), .stat_rd(stat_rd),
    .status(status), .alert_n(alert_n)
  );

  always_comb begin
    case (alert_addr_e'(reg_addr))
      ADDR_CFG: reg_rdata = {{(TH_W-1){1'b0}}, en};
      ADDR_HI:  reg_rdata = hi_field;
      ADDR_LO:  reg_rdata = lo_field;
      default:  reg_rdata = TH_W'(status);
    endcase
  end

  // R10: a write to the config address shows up in the next cycle
  a_r10_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> (en == $past(reg_wdata[0])));
endmodule

// File: tb/sim_adc_range_alert.sv
`timescale 1ns/1ps
module sim_adc_range_alert;
  localparam int NCH = 4;
  logic clk = 0, rst_n = 0;
  logic conv_done = 0, cs_n = 1, reg_wr = 0, reg_rd = 0;
  logic [63:0] samples = '0;
  logic [1:0]  reg_addr = 0;
  logic [11:0] reg_wdata = 0;
  logic [11:0] reg_rdata;
  logic alert_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adc_range_alert u0 (.clk(clk), .rst_n(rst_n), .conv_done(conv_done), .samples(samples),
    .cs_n(cs_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alert_n(alert_n));

  // behavioural reference model
  int m_en, m_hi, m_lo, m_stat, m_latch, m_csq;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_hi = 'h7FF; m_lo = 'h800; m_stat = 0; m_latch = 0; m_csq = 1;
    end else begin
      int hits, fall;
      hits = 0;
      if (conv_done && m_en != 0)
        for (int c = 0; c < NCH; c++) begin
          int s;
          s = int'(samples[c*16 +: 16]);
          if (s > m_hi * 16 + 15) hits = hits | (1 << c);
          if (s < m_lo * 16)      hits = hits | (1 << (NCH + c));
        end
      fall = (m_csq == 1 && cs_n == 0) ? 1 : 0;
      if (fall == 1 || (reg_rd && reg_addr == 3)) m_stat = 0;
      m_stat = m_stat | hits;
      if (m_en == 0) m_latch = 0;
      else if (hits != 0) m_latch = 1;
      else if (fall == 1) m_latch = 0;
      if (reg_wr) case (reg_addr)
        0: m_en = int'(reg_wdata[0]);
        1: m_hi = int'(reg_wdata);
        2: m_lo = int'(reg_wdata);
        default: ;
      endcase
      m_csq = int'(cs_n);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // compare against the model at every falling edge
  always @(negedge clk) if (rst_n && !done) begin
    int e;
    case (reg_addr)
      0: e = m_en; 1: e = m_hi; 2: e = m_lo; default: e = m_stat;
    endcase
    chk("R10 model rdata", int'(reg_rdata), e);
    chk("R4 model alert_n", int'(alert_n), m_latch == 1 ? 0 : 1);
  end

  task automatic step(input bit wr, input bit rd, input int addr, input int wd,
                      input bit conv, input logic [63:0] smp, input bit cs);
    #2;
    reg_wr = wr; reg_rd = rd; reg_addr = 2'(addr); reg_wdata = 12'(wd);
    conv_done = conv; samples = smp; cs_n = cs;
    @(negedge clk);
  endtask

  function automatic logic [63:0] pk(input logic [15:0] c0, c1, c2, c3);
    return {c3, c2, c1, c0};
  endfunction

  localparam logic [15:0] MID = 16'h8000;

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    step(0,0,0,0,0,'0,1); chk("R1 enable", int'(reg_rdata), 0); chk("R1 alert_n", int'(alert_n), 1);
    step(0,0,1,0,0,'0,1); chk("R1 upper field", int'(reg_rdata), 'h7FF);
    step(0,0,2,0,0,'0,1); chk("R1 lower field", int'(reg_rdata), 'h800);
    step(0,0,3,0,0,'0,1); chk("R1 status", int'(reg_rdata), 0);
    step(1,0,1,'hC00,0,'0,1);
    step(1,0,2,'h400,0,'0,1);
    step(1,0,0,1,0,'0,1);
    step(0,0,0,0,0,'0,1); chk("R10 enable readback", int'(reg_rdata), 1);
    step(0,0,1,0,0,'0,1); chk("R10 upper readback", int'(reg_rdata), 'hC00);
    step(0,0,3,0,1,pk(MID,MID,MID,MID),1);
    chk("R2 in range status", int'(reg_rdata), 0); chk("R3 in range alert_n", int'(alert_n), 1);
    step(0,0,3,0,1,pk(MID,16'hC00F,16'h4000,MID),1);
    chk("R2 R3 equal limits no trip", int'(reg_rdata), 0);
    step(0,0,3,0,1,pk(MID,16'hC010,MID,MID),1);
    chk("R2 high ch1", int'(reg_rdata), 'h02); chk("R4 alert low", int'(alert_n), 0);
    step(0,0,3,0,1,pk(MID,MID,MID,MID),1);
    chk("R5 status held", int'(reg_rdata), 'h02); chk("R5 alert held", int'(alert_n), 0);
    step(0,0,3,0,0,'0,0);
    chk("R6 fall clears status", int'(reg_rdata), 0); chk("R6 fall releases", int'(alert_n), 1);
    step(0,0,3,0,1,pk(MID,MID,MID,16'h3FFF),0);
    chk("R3 low ch3", int'(reg_rdata), 'h80); chk("R4 alert low ch3", int'(alert_n), 0);
    step(0,0,3,0,0,'0,1);
    chk("R6 rise keeps status", int'(reg_rdata), 'h80); chk("R6 rise keeps alert", int'(alert_n), 0);
    step(0,1,3,0,0,'0,1);
    chk("R8 read clears status", int'(reg_rdata), 0); chk("R8 read keeps alert", int'(alert_n), 0);
    step(0,1,3,0,1,pk(16'h0000,MID,MID,MID),1);
    chk("R8 same-cycle hit kept", int'(reg_rdata), 'h10);
    step(0,0,3,0,1,pk(MID,MID,16'hFFFF,MID),0);
    chk("R9 hit wins over fall status", int'(reg_rdata), 'h04); chk("R9 alert low", int'(alert_n), 0);
    step(0,0,3,0,0,'0,1);
    step(0,0,3,0,0,'0,0);
    chk("R6 second fall", int'(alert_n), 1);
    step(0,0,3,0,1,pk(16'hFFFF,MID,MID,MID),0);
    chk("R2 high ch0", int'(reg_rdata), 'h01);
    step(1,0,0,0,0,'0,0);
    step(0,0,3,0,0,'0,0);
    chk("R7 disable releases", int'(alert_n), 1);
    step(0,0,3,0,1,pk(MID,MID,MID,16'hFFFF),0);
    chk("R7 no new status", int'(reg_rdata), 'h01); chk("R7 alert stays high", int'(alert_n), 1);
    step(0,0,3,0,0,'0,0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule